// File: doc/BRIEF.md
# Interrupt Enable and Pending Controller

This block gates 114 interrupt lines. Each line has an enable bit and a pending latch. Software reaches the enable bits through a simple word-wide register bus. One window of words sets enable bits. A second window of words clears them. A privilege flag on every access decides whether the access has any effect at all.

An incoming line request always latches into the line's pending bit, whether or not the line is enabled. Among the lines that are both pending and enabled, the block picks the one with the smallest priority value and presents it as an activation request together with its index. The priority values come in from outside. When the consumer acknowledges the request, the pending bit of the presented line is dropped. A line that is pending but disabled stays latched and waits: it becomes a candidate as soon as software enables it.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, every enable bit and every pending bit is 0, every register word reads 0 and `act_valid` is 0.
- R2: Set words are at byte addresses 0x100, 0x104, 0x108 and 0x10C (word k at 0x100+4k). Bit n of word k belongs to line 32k+n. A privileged write of 1 to a bit enables the line, and a written 0 leaves the bit unchanged.
- R3: Clear words are at 0x180+4k with the same bit-to-line mapping. A privileged write of 1 disables the line, and a written 0 leaves the bit unchanged. No other access can turn an enable bit off.
- R4: A privileged read of a set word or a clear word returns the current enable bits of that word. Bits 18 to 31 of word 3 do not exist: they always read 0, and writes to them are dropped.
- R5: When `bus_priv` is 0, a write changes nothing and a read returns 0.
- R6: A line that is high on `irq_in` at a rising clock edge is pending after that edge, whether or not it is enabled.
- R7: `act_valid` is 1 exactly when at least one line is both pending and enabled. A line that is pending but disabled is never presented, whatever its priority.
- R8: The priority of line i is `irq_prio[i*3 +: 3]`. Among the candidates, the smallest priority value wins. When values are equal, the lowest line index wins. The winner's index appears on `act_index`.
- R9: `act_ack` sampled high while `act_valid` is 1 clears the pending bit of the line on `act_index` at that edge. If that same line is also high on `irq_in` in that cycle, it stays pending.
- R10: A read of any address outside the two windows returns 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_priv | input | 1 | 1 when the access is privileged |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_in | input | 114 | Level request per line |
| irq_prio | input | 342 | 3-bit priority value per line, line i at bits i*3+2:i*3 |
| act_valid | output | 1 | An enabled, pending line is being presented |
| act_index | output | 7 | Index of the presented line |
| act_ack | input | 1 | Consumer accepts the presented line |

## Verification
A wrong enable bit shows up on the very next read of its set word or clear word. It also shows up on the activation outputs in the cycle after its line becomes pending. A pending latch that is lost or stuck shows up on `act_valid` and `act_index` in the cycle after the request or the acknowledge that should have changed it. The bench keeps its own model of enables, pending bits and priorities. It compares register reads and activation results against that model one cycle after each stimulus, so a fault is reported in the cycle where it first becomes visible at the ports.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int WORD_W   = 32;
  localparam int SET_BASE = 'h100;
  localparam int CLR_BASE = 'h180;

  // Aligned address inside a window of nwords words starting at base
  function automatic logic in_window(logic [31:0] addr, int base, int nwords);
    return (addr >= 32'(base)) && (addr < 32'(base + 4 * nwords)) && (addr[1:0] == 2'b00);
  endfunction

  // Word number of an address relative to a window base
  function automatic int word_of(logic [31:0] addr, int base);
    return int'((addr - 32'(base)) >> 2);
  endfunction

  // Bits of word w that map to a real line
  function automatic logic [WORD_W-1:0] impl_mask(int w, int nlines);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) m[b] = ((w * WORD_W + b) < nlines);
    return m;
  endfunction

  // Priority field of line i from a packed vector
  function automatic logic [7:0] prio_of(logic [1023:0] vec, int i, int pw);
    logic [7:0] p;
    p = '0;
    for (int b = 0; b < pw; b++) p[b] = vec[i * pw + b];
    return p;
  endfunction
endpackage

// File: rtl/irqg_enable_bank.sv
module irqg_enable_bank
  import irqg_pkg::*;
#(
  parameter int NUM_LINES = 114,
  parameter int ADDR_W    = 12,
  localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_priv,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] en_flat
);
  logic [31:0]          addr32;
  logic [NUM_WORDS-1:0] set_hit;
  logic [NUM_WORDS-1:0] clr_hit;
  logic [NUM_WORDS-1:0] set_we;
  logic [NUM_WORDS-1:0] clr_we;
  logic                 set_we_any;
  logic                 clr_we_any;
  logic [WORD_W-1:0]    en_word [NUM_WORDS];

  assign addr32 = 32'(bus_addr);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] MASK = impl_mask(w, NUM_LINES);
    assign set_hit[w] = bus_priv && in_window(addr32, SET_BASE, NUM_WORDS)
                        && (word_of(addr32, SET_BASE) == w);
    assign clr_hit[w] = bus_priv && in_window(addr32, CLR_BASE, NUM_WORDS)
                        && (word_of(addr32, CLR_BASE) == w);
    assign set_we[w]  = bus_we && set_hit[w];
    assign clr_we[w]  = bus_we && clr_hit[w];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_word[w] <= '0;
      else if (set_we[w]) en_word[w] <= en_word[w] | (bus_wdata & MASK);
      else if (clr_we[w]) en_word[w] <= en_word[w] & ~(bus_wdata & MASK);
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_flat
    assign en_flat[i] = en_word[i / WORD_W][i % WORD_W];
  end

  assign set_we_any = |set_we;
  assign clr_we_any = |clr_we;

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (set_hit[w] || clr_hit[w]) bus_rdata = en_word[w];
  end

  assert_set_only_by_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !set_we_any |=> ((en_flat & ~$past(en_flat)) == '0));
  assert_clear_only_by_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_any |=> ((en_flat & $past(en_flat)) == $past(en_flat)));
  assert_unpriv_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_priv |-> (bus_rdata == '0));
  assert_unpriv_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_priv) |=> $stable(en_flat));
endmodule

// File: rtl/irqg_pending.sv
module irqg_pending #(
  parameter int NUM_LINES = 114,
  parameter int IDX_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 ack_fire,
  input  logic [IDX_W-1:0]     ack_index,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] ack_mask;

  always_comb begin
    ack_mask = '0;
    for (int i = 0; i < NUM_LINES; i++)
      ack_mask[i] = ack_fire && (ack_index == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack_mask) | irq_in;
  end

  assert_pend_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_in) |=> ((pend & $past(irq_in)) == $past(irq_in)));
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !irq_in[ack_index]) |=> !pend[$past(ack_index)]);
  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_mask));
endmodule

// File: rtl/irqg_select.sv
module irqg_select
  import irqg_pkg::*;
#(
  parameter int NUM_LINES = 114,
  parameter int PRIO_W    = 3,
  parameter int IDX_W     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        cand,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_vec,
  output logic                        win_valid,
  output logic [IDX_W-1:0]            win_index
);
  logic [1023:0] prio_wide;
  logic [7:0]    best_p;

  assign prio_wide = 1024'(prio_vec);

  // Linear scan; strict less-than keeps the lower index on ties
  always_comb begin
    win_valid = 1'b0;
    win_index = '0;
    best_p    = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!win_valid || (prio_of(prio_wide, i, PRIO_W) < best_p))) begin
        win_valid = 1'b1;
        win_index = IDX_W'(i);
        best_p    = prio_of(prio_wide, i, PRIO_W);
      end
    end
  end

  assert_act_is_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_index]);
  assert_idle_when_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|cand) |-> !win_valid);
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irqg_pkg::*;
#(
  parameter int NUM_LINES = 114,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 12,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  input  logic                        bus_priv,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic [NUM_LINES-1:0]        irq_in,
  input  logic [NUM_LINES*PRIO_W-1:0] irq_prio,
  output logic                        act_valid,
  output logic [IDX_W-1:0]            act_index,
  input  logic                        act_ack
);
  logic [NUM_LINES-1:0] en_flat;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] cand;
  logic                 ack_fire;

  irqg_enable_bank #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_priv(bus_priv), .bus_rdata(bus_rdata), .en_flat(en_flat)
  );

  assign ack_fire = act_ack && act_valid;

  irqg_pending #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_fire(ack_fire),
    .ack_index(act_index), .pend(pend)
  );

  assign cand = pend & en_flat;

  irqg_select #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .cand(cand), .prio_vec(irq_prio),
    .win_valid(act_valid), .win_index(act_index)
  );

  assert_disabled_never_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> en_flat[act_index]);
endmodule

// File: tb/test_irq_gate_ctrl.sv
module test_irq_gate_ctrl;
  localparam int N  = 114;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_priv = 1'b1;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic [N*PW-1:0] irq_prio;
  logic          act_valid;
  logic [6:0]    act_index;
  logic          act_ack = 1'b0;

  bit        m_en   [N];
  bit        m_pend [N];
  logic [2:0] m_prio [N];

  typedef struct {
    int          kind;   // 0 = read data, 1 = activation
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  always_comb
    for (int i = 0; i < N; i++) irq_prio[i*PW +: PW] = m_prio[i];

  irq_gate_ctrl i_irq_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_priv(bus_priv), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_prio(irq_prio), .act_valid(act_valid), .act_index(act_index), .act_ack(act_ack)
  );

  // Monitor: pop one expected item per cycle and compare
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      checks++;
      if (it.kind == 0) begin
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: rdata actual=%08h expected=%08h", it.tag, bus_rdata, it.exp);
        end
      end else begin
        act = {24'b0, act_valid, act_index};
        if ((act_valid !== it.exp[7]) || (it.exp[7] && act !== it.exp)) begin
          fails++;
          $display("FAIL %s: act actual=%0b/%0d expected=%0b/%0d",
                   it.tag, act_valid, act_index, it.exp[7], it.exp[6:0]);
        end
      end
    end
  end

  function automatic logic [31:0] exp_read(logic [11:0] a, logic p);
    logic [31:0] r;
    int base;
    r = '0;
    if (p && a[1:0] == 2'b00) begin
      base = -1;
      if (a >= 12'h100 && a < 12'h110) base = 'h100;
      if (a >= 12'h180 && a < 12'h190) base = 'h180;
      if (base >= 0)
        for (int b = 0; b < 32; b++) begin
          int ln;
          ln = (int'(a) - base) / 4 * 32 + b;
          if (ln < N) r[b] = m_en[ln];
        end
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_act();
    int best;
    best = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
    return (best < 0) ? 32'h0 : (32'h80 | 32'(best));
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic p);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_priv = p;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_priv = 1'b1;
    if (p && a[1:0] == 2'b00)
      for (int b = 0; b < 32; b++) begin
        int ln;
        if (a >= 12'h100 && a < 12'h110) begin
          ln = (int'(a) - 'h100) / 4 * 32 + b;
          if (ln < N && d[b]) m_en[ln] = 1;
        end
        if (a >= 12'h180 && a < 12'h190) begin
          ln = (int'(a) - 'h180) / 4 * 32 + b;
          if (ln < N && d[b]) m_en[ln] = 0;
        end
      end
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic p, input string tag);
    sb_item_t it;
    @(posedge clk); #2;
    bus_addr = a; bus_priv = p;
    it.kind = 0; it.exp = exp_read(a, p); it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
    bus_priv = 1'b1;
  endtask

  task automatic chk_act(input string tag);
    sb_item_t it;
    it.kind = 1; it.exp = exp_act(); it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(posedge clk); #2;
    irq_in = m;
    @(posedge clk); #2;
    irq_in = '0;
    for (int i = 0; i < N; i++) if (m[i]) m_pend[i] = 1;
  endtask

  task automatic ack(input int hold_line);
    logic [31:0] w;
    w = exp_act();
    @(posedge clk); #2;
    act_ack = 1'b1;
    if (hold_line >= 0) irq_in[hold_line] = 1'b1;
    @(posedge clk); #2;
    act_ack = 1'b0; irq_in = '0;
    if (w[7]) m_pend[int'(w[6:0])] = 0;
    if (hold_line >= 0) m_pend[hold_line] = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pend[i] = 0; m_prio[i] = 3'd7; end
    m_prio[2] = 3'd3; m_prio[100] = 3'd3; m_prio[50] = 3'd1; m_prio[1] = 3'd0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 4; k++) chk_rd(12'(12'h100 + 4 * k), 1'b1, "R1");
    chk_act("R1");

    // R2 set, zero is no-op; R4 read via both windows
    bus_wr(12'h100, 32'h0000_0005, 1'b1);
    chk_rd(12'h100, 1'b1, "R2");
    bus_wr(12'h100, 32'h0, 1'b1);
    chk_rd(12'h100, 1'b1, "R2");
    chk_rd(12'h180, 1'b1, "R4");
    bus_wr(12'h10C, 32'hFFFF_FFFF, 1'b1);
    chk_rd(12'h10C, 1'b1, "R4");
    chk_rd(12'h18C, 1'b1, "R4");

    // R3 clear semantics
    bus_wr(12'h18C, 32'h0002_0000, 1'b1);
    chk_rd(12'h10C, 1'b1, "R3");
    bus_wr(12'h180, 32'h0, 1'b1);
    chk_rd(12'h100, 1'b1, "R3");

    // R5 unprivileged access
    bus_wr(12'h104, 32'hFFFF_FFFF, 1'b0);
    chk_rd(12'h104, 1'b1, "R5");
    bus_wr(12'h180, 32'hFFFF_FFFF, 1'b0);
    chk_rd(12'h100, 1'b1, "R5");
    chk_rd(12'h100, 1'b0, "R5");

    // R10 outside the windows
    bus_wr(12'h140, 32'hFFFF_FFFF, 1'b1);
    chk_rd(12'h140, 1'b1, "R10");
    chk_rd(12'h104, 1'b1, "R10");
    chk_rd(12'h110, 1'b1, "R10");

    // R6 / R7: disabled line latches but is not presented
    m = '0; m[50] = 1'b1;
    pulse(m);
    chk_act("R7");
    bus_wr(12'h104, 32'h0004_0000, 1'b1);
    chk_act("R6");
    ack(-1);
    chk_act("R9");

    // R8 tie on value goes to lower index; disabled prio 0 line ignored
    m = '0; m[1] = 1'b1; m[2] = 1'b1; m[100] = 1'b1;
    pulse(m);
    chk_act("R8");
    m = '0; m[0] = 1'b1;
    pulse(m);
    chk_act("R8");
    ack(-1);
    chk_act("R9");
    ack(-1);
    chk_act("R9");
    ack(0);
    chk_act("R9");

    // R8 smaller value beats lower index
    m = '0; m[100] = 1'b1;
    pulse(m);
    chk_act("R8");
    ack(-1);
    chk_act("R9");

    // R7 clearing an enable hides a pending line
    bus_wr(12'h180, 32'h0000_0001, 1'b1);
    chk_act("R7");
    chk_rd(12'h180, 1'b1, "R3");

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule